// File: doc/BRIEF.md
# Strided Vector Extremum Index Finder

The block walks a vector of two's-complement integers held in a word-addressed memory. It reports the one-based position of the largest or smallest element. As an option it ranks elements by their absolute values. A controller supplies a base address, a signed stride counted in elements, a signed element count and a destination address, then pulses `start`. The block issues its reads one at a time over a single request/response memory port. At the end it writes one word, the one-based index of the winning element, to the destination address and pulses `done`.

Each element is either two words (narrow) or four words (wide). The most significant word sits at the lowest address. The block ranks elements by a subtract-and-test-sign rule against the running best. Ties therefore resolve differently in the two directions: a maximum search keeps the earliest of equal values, and a minimum search moves to the latest. A count of zero or below ends the operation at once, without touching memory.

The memory port uses valid/ready. Once `req_valid` is raised, the block holds the request and its address, write flag and data unchanged until `req_ready` is seen high at a clock edge. After a read is accepted, the block raises no new request until `rsp_valid` returns that word. `rsp_valid` has no ready, so the block always takes a response. Control pins (`start`, `busy`, `done`) are plain levels and pulses.

Top module: `vxi_extremum_index`

## Requirements
- R1: During and after reset, `busy`, `done` and `req_valid` are low, and while not busy the block never raises `req_valid`.
- R2: With `find_max`=1 and `use_abs`=0, the written index is that of the largest signed element, compared exactly over the full element range. Among equal maxima the earliest element wins.
- R3: With `find_max`=0 and `use_abs`=0, the written index is that of the smallest signed element. Among equal minima the latest element wins.
- R4: With `use_abs`=1, every element, the first included, is ranked by its magnitude: negative values are negated, and the most negative value of the element width becomes the most positive value of that width. Tie rules follow R2 and R3.
- R5: `wide`=0 selects 2-word elements and `wide`=1 selects 4-word elements. The word at the lowest address is the most significant, and a narrow element is a 32-bit signed value when WORD_W is 16.
- R6: Element i starts at `base_addr` + i*`stride`*(2 or 4), modulo 2^ADDR_W. The stride is signed, and zero and negative strides are legal.
- R7: A run with a positive count ends with exactly one memory write: address `result_addr`, data equal to the zero-based winning position plus one.
- R8: A `start` with a signed `count` of zero or below makes no memory request, and `done` rises in the next cycle.
- R9: `done` is a one-cycle pulse, high in the cycle after the result write is accepted. `busy` is high from the cycle after an accepted `start` until the cycle after `done`.
- R10: A request is held stable while `req_valid` is high and `req_ready` is low. No request is raised while a read response is outstanding.
- R11: `start` is ignored while `busy` is high: it changes neither the result nor the number of writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (taken only when idle) |
| find_max | input | 1 | 1 = maximum search, 0 = minimum search |
| use_abs | input | 1 | Rank by absolute value |
| wide | input | 1 | 0 = 2-word elements, 1 = 4-word elements |
| base_addr | input | ADDR_W | Address of element 0 |
| stride | input | WORD_W | Signed element stride |
| count | input | WORD_W | Signed element count |
| result_addr | input | ADDR_W | Destination of the index word |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Request word address |
| req_wdata | output | WORD_W | Write data |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | WORD_W | Read data |

## Verification
The bench runs every three-element vector drawn from {-1, +1, most negative, most positive} in both widths and all four modes. This catches a comparator that subtracts in the element width and wraps, which would place the most negative value above the most positive. It also catches swapped tie rules, which would move the maximum to the later of two equal values, and an unsaturated absolute value, which would turn the most negative value into itself. Zero, negative and address-wrapping strides expose a design that ignores the stride sign or scales it by the wrong element size. Counts of zero and below, together with a `start` pulsed mid-run, expose a design that writes anyway or restarts.

// File: rtl/vxi_pkg.sv
package vxi_pkg;
  localparam int NARROW_WORDS = 2;
  localparam int WIDE_WORDS   = 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_REQ,
    S_RD_WAIT,
    S_EVAL,
    S_WR_REQ,
    S_DONE
  } vxi_state_t;
endpackage

// File: rtl/vxi_lane_gather.sv
module vxi_lane_gather #(
  parameter int WORD_W = 16,
  parameter int LANES  = 4,
  parameter int SEL_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [SEL_W-1:0]        lane,
  input  logic                    wide,
  input  logic [WORD_W-1:0]       word_in,
  output logic [LANES*WORD_W-1:0] value
);
  localparam int ELEM_W = LANES * WORD_W;
  localparam int HALF_W = ELEM_W / 2;

  logic [WORD_W-1:0] lane_q [LANES];
  logic [ELEM_W-1:0] full;
  logic [HALF_W-1:0] half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < LANES; j++) lane_q[j] <= '0;
    end else if (load) begin
      for (int j = 0; j < LANES; j++)
        if (lane == SEL_W'(j)) lane_q[j] <= word_in;
    end
  end

  // Lane 0 holds the word fetched from the lowest address: most significant.
  for (genvar j = 0; j < LANES; j++) begin : g_pack
    assign full[ELEM_W-1-j*WORD_W -: WORD_W] = lane_q[j];
  end

  assign half  = full[ELEM_W-1 -: HALF_W];
  assign value = wide ? full : {{HALF_W{half[HALF_W-1]}}, half};
endmodule

// File: rtl/vxi_abs_sat.sv
module vxi_abs_sat #(
  parameter int ELEM_W = 64
) (
  input  logic [ELEM_W-1:0] value_in,
  input  logic              enable,
  input  logic              wide,
  output logic [ELEM_W-1:0] value_out
);
  localparam int HALF_W = ELEM_W / 2;
  localparam logic [ELEM_W-1:0] FULL_MIN = {1'b1, {(ELEM_W-1){1'b0}}};
  localparam logic [ELEM_W-1:0] FULL_MAX = {1'b0, {(ELEM_W-1){1'b1}}};
  localparam logic [ELEM_W-1:0] HALF_MIN = {{(ELEM_W-HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};
  localparam logic [ELEM_W-1:0] HALF_MAX = {{(ELEM_W-HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};

  logic negative;
  assign negative = value_in[ELEM_W-1];

  always_comb begin
    if (!enable || !negative)             value_out = value_in;
    else if (wide && value_in == FULL_MIN)  value_out = FULL_MAX;
    else if (!wide && value_in == HALF_MIN) value_out = HALF_MAX;
    else                                    value_out = -value_in;
  end
endmodule

// File: rtl/vxi_pick.sv
module vxi_pick #(
  parameter int ELEM_W = 64
) (
  input  logic [ELEM_W-1:0] best,
  input  logic [ELEM_W-1:0] cand,
  input  logic              want_max,
  output logic              take
);
  // One extra bit keeps best - cand exact for any pair of signed inputs.
  logic [ELEM_W:0] diff;
  logic            below;

  assign diff  = {best[ELEM_W-1], best} - {cand[ELEM_W-1], cand};
  assign below = diff[ELEM_W];
  assign take  = want_max ? below : !below;
endmodule

// File: rtl/vxi_extremum_index.sv
module vxi_extremum_index
  import vxi_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              find_max,
  input  logic              use_abs,
  input  logic              wide,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [WORD_W-1:0] stride,
  input  logic [WORD_W-1:0] count,
  input  logic [ADDR_W-1:0] result_addr,
  output logic              busy,
  output logic              done,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [WORD_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data
);
  localparam int ELEM_W    = WORD_W * WIDE_WORDS;
  localparam int SEL_W     = $clog2(WIDE_WORDS);
  localparam int NARROW_SH = $clog2(NARROW_WORDS);
  localparam int WIDE_SH   = $clog2(WIDE_WORDS);

  vxi_state_t state_q;

  logic              max_q, abs_q, wide_q;
  logic [ADDR_W-1:0] ptr_q, step_q, res_addr_q;
  logic [WORD_W-1:0] count_q, elem_q, best_idx_q;
  logic [SEL_W-1:0]  word_q;
  logic [ELEM_W-1:0] best_q;

  logic [ADDR_W-1:0] stride_ext, step_d;
  logic [SEL_W-1:0]  last_word;
  logic              count_pos, last_elem, rsp_take;
  logic [ELEM_W-1:0] raw_value, cand;
  logic              take;

  assign stride_ext = ADDR_W'($signed(stride));
  assign step_d     = wide ? (stride_ext << WIDE_SH) : (stride_ext << NARROW_SH);
  assign last_word  = wide_q ? SEL_W'(WIDE_WORDS - 1) : SEL_W'(NARROW_WORDS - 1);
  assign count_pos  = $signed(count) > 0;
  assign last_elem  = (elem_q == count_q - WORD_W'(1));
  assign rsp_take   = (state_q == S_RD_WAIT) && rsp_valid;

  vxi_lane_gather #(
    .WORD_W (WORD_W),
    .LANES  (WIDE_WORDS),
    .SEL_W  (SEL_W)
  ) u_gather (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (rsp_take),
    .lane    (word_q),
    .wide    (wide_q),
    .word_in (rsp_data),
    .value   (raw_value)
  );

  vxi_abs_sat #(.ELEM_W(ELEM_W)) u_abs (
    .value_in  (raw_value),
    .enable    (abs_q),
    .wide      (wide_q),
    .value_out (cand)
  );

  vxi_pick #(.ELEM_W(ELEM_W)) u_pick (
    .best     (best_q),
    .cand     (cand),
    .want_max (max_q),
    .take     (take)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      max_q      <= 1'b0;
      abs_q      <= 1'b0;
      wide_q     <= 1'b0;
      ptr_q      <= '0;
      step_q     <= '0;
      res_addr_q <= '0;
      count_q    <= '0;
      elem_q     <= '0;
      word_q     <= '0;
      best_q     <= '0;
      best_idx_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (start) begin
            max_q      <= find_max;
            abs_q      <= use_abs;
            wide_q     <= wide;
            ptr_q      <= base_addr;
            step_q     <= step_d;
            res_addr_q <= result_addr;
            count_q    <= count;
            elem_q     <= '0;
            word_q     <= '0;
            best_idx_q <= '0;
            state_q    <= count_pos ? S_RD_REQ : S_DONE;
          end
        end
        S_RD_REQ: begin
          if (req_ready) state_q <= S_RD_WAIT;
        end
        S_RD_WAIT: begin
          if (rsp_valid) begin
            if (word_q == last_word) begin
              state_q <= S_EVAL;
            end else begin
              word_q  <= word_q + SEL_W'(1);
              state_q <= S_RD_REQ;
            end
          end
        end
        S_EVAL: begin
          // Element 0 seeds the running best; comparing it with itself
          // afterwards would leave the index at 0 in either direction.
          if (elem_q == '0 || take) begin
            best_q     <= cand;
            best_idx_q <= elem_q;
          end
          if (last_elem) begin
            state_q <= S_WR_REQ;
          end else begin
            elem_q  <= elem_q + WORD_W'(1);
            ptr_q   <= ptr_q + step_q;
            word_q  <= '0;
            state_q <= S_RD_REQ;
          end
        end
        S_WR_REQ: begin
          if (req_ready) state_q <= S_DONE;
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_DONE);
  assign req_valid = (state_q == S_RD_REQ) || (state_q == S_WR_REQ);
  assign req_write = (state_q == S_WR_REQ);
  assign req_addr  = (state_q == S_WR_REQ) ? res_addr_q : ptr_q + ADDR_W'(word_q);
  assign req_wdata = best_idx_q + WORD_W'(1);
endmodule

// File: rtl/vxi_extremum_index_chk.sv
module vxi_extremum_index_chk #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [WORD_W-1:0] count,
  input logic              busy,
  input logic              done,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [WORD_W-1:0] req_wdata,
  input logic              rsp_valid
);
  logic rd_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_pend <= 1'b0;
    else if (req_valid && req_ready && !req_write) rd_pend <= 1'b1;
    else if (rsp_valid) rd_pend <= 1'b0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_write) && $stable(req_wdata)));

  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> !req_valid);

  p_short_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && $signed(count) <= 0) |=> (done && !req_valid));

  p_done_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> done);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_one_based_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> (req_wdata != '0));
endmodule

bind vxi_extremum_index vxi_extremum_index_chk #(
  .WORD_W (WORD_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .count     (count),
  .busy      (busy),
  .done      (done),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid)
);

// File: tb/vxi_extremum_index_test.sv
module vxi_extremum_index_test;
  localparam logic [15:0] RES  = 16'h0300;
  localparam logic [15:0] RES2 = 16'h0310;
  localparam longint MINW = 64'sh8000000000000000;
  localparam longint MAXW = 64'sh7FFFFFFFFFFFFFFF;
  localparam longint MINN = -64'sd2147483648;
  localparam longint MAXN = 64'sd2147483647;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, find_max = 1'b0, use_abs = 1'b0, wide = 1'b0;
  logic [15:0] base_addr = '0, stride = '0, count = '0, result_addr = '0;
  logic        busy, done, req_valid, req_write;
  logic        req_ready = 1'b0;
  logic [15:0] req_addr, req_wdata;
  logic        rsp_valid = 1'b0;
  logic [15:0] rsp_data = '0;

  int checks = 0, fails = 0;
  int wr_cnt = 0, acc_cnt = 0;
  logic [15:0] mem [0:1023];
  logic [15:0] lfsr = 16'hACE1;
  logic        pend = 1'b0;
  logic [1:0]  dly = '0;
  logic [15:0] rd_q = '0;

  always #4 clk = ~clk;

  vxi_extremum_index uut (
    .clk(clk), .rst_n(rst_n), .start(start), .find_max(find_max),
    .use_abs(use_abs), .wide(wide), .base_addr(base_addr), .stride(stride),
    .count(count), .result_addr(result_addr), .busy(busy), .done(done),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data)
  );

  // Memory model: random back-pressure and 1..2 cycle read latency.
  always @(posedge clk) begin
    lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    req_ready <= (lfsr[2:0] != 3'd0);
    rsp_valid <= 1'b0;
    if (pend) begin
      if (dly == 2'd0) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_q;
        pend      <= 1'b0;
      end else begin
        dly <= dly - 2'd1;
      end
    end
    if (req_valid && req_ready) begin
      acc_cnt = acc_cnt + 1;
      if (req_write) begin
        mem[req_addr[9:0]] = req_wdata;
        wr_cnt = wr_cnt + 1;
      end else begin
        rd_q <= mem[req_addr[9:0]];
        pend <= 1'b1;
        dly  <= {1'b0, lfsr[4]};
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] a, input longint v, input bit w);
    logic [15:0] t;
    logic [31:0] s;
    if (w) begin
      for (int k = 0; k < 4; k++) begin
        t = a + 16'(k);
        mem[t[9:0]] = v[63-16*k -: 16];
      end
    end else begin
      s = v[31:0];
      t = a;          mem[t[9:0]] = s[31:16];
      t = a + 16'd1;  mem[t[9:0]] = s[15:0];
    end
  endtask

  function automatic longint getv(input logic [15:0] a, input bit w);
    logic [15:0] t0, t1, t2, t3;
    t0 = a; t1 = a + 16'd1; t2 = a + 16'd2; t3 = a + 16'd3;
    if (w) return longint'({mem[t0[9:0]], mem[t1[9:0]], mem[t2[9:0]], mem[t3[9:0]]});
    return longint'($signed({mem[t0[9:0]], mem[t1[9:0]]}));
  endfunction

  function automatic longint absv(input longint v, input bit w);
    if (v >= 0) return v;
    if (w && v == MINW) return MAXW;
    if (!w && v == MINN) return MAXN;
    return -v;
  endfunction

  function automatic int ref_idx(input logic [15:0] base, input logic [15:0] strd,
                                 input int n, input bit w, input bit mx, input bit ab);
    logic [15:0] a;
    longint best, c;
    int bi, words;
    words = w ? 4 : 2;
    a = base;
    bi = 0;
    best = ab ? absv(getv(a, w), w) : getv(a, w);
    for (int i = 0; i < n; i++) begin
      c = ab ? absv(getv(a, w), w) : getv(a, w);
      if (mx ? (best < c) : (best >= c)) begin
        best = c;
        bi = i;
      end
      a = a + 16'($signed(strd) * words);
    end
    return bi + 1;
  endfunction

  function automatic longint pick_val(input int code, input bit w);
    case (code)
      0: return -64'sd1;
      1: return 64'sd1;
      2: return w ? MINW : MINN;
      default: return w ? MAXW : MAXN;
    endcase
  endfunction

  function automatic string mode_tag(input bit mx, input bit ab, input bit w);
    string t;
    t = ab ? "R4" : (mx ? "R2" : "R3");
    return $sformatf("%s R5 wide=%0d max=%0d", t, w, mx);
  endfunction

  task automatic run_case(input logic [15:0] base, input logic [15:0] strd, input int n,
                          input bit w, input bit mx, input bit ab, input string tag);
    int exp, w0;
    bit seen;
    exp = ref_idx(base, strd, n, w, mx, ab);
    w0 = wr_cnt;
    seen = 0;
    mem[RES[9:0]] = 16'hDEAD;
    @(negedge clk);
    start = 1'b1; base_addr = base; stride = strd; count = 16'(n);
    wide = w; find_max = mx; use_abs = ab; result_addr = RES;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 5000 && !seen; c++) begin
      if (done) seen = 1;
      else @(negedge clk);
    end
    check(seen, "R9 done seen", longint'(seen), 1);
    check(wr_cnt - w0 == 1, "R7 single write", longint'(wr_cnt - w0), 1);
    check(mem[RES[9:0]] == 16'(exp), tag, longint'(mem[RES[9:0]]), longint'(exp));
    @(negedge clk);
    check(!done && !busy, "R9 done one cycle then idle", longint'({done, busy}), 0);
  endtask

  task automatic short_case(input logic [15:0] n);
    int a0;
    a0 = acc_cnt;
    mem[RES[9:0]] = 16'hBEEF;
    @(negedge clk);
    start = 1'b1; count = n; base_addr = 16'h0010; stride = 16'd1; result_addr = RES;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R8 done next cycle", longint'(done), 1);
    @(negedge clk);
    check(!done && !busy, "R8 back to idle", longint'({done, busy}), 0);
    check(acc_cnt == a0, "R8 no memory access", longint'(acc_cnt - a0), 0);
    check(mem[RES[9:0]] == 16'hBEEF, "R8 result untouched", longint'(mem[RES[9:0]]), 48879);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !req_valid, "R1 reset outputs", longint'({busy, done, req_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !req_valid, "R1 idle after reset", longint'({busy, req_valid}), 0);

    // Exhaustive 3-element sweep over edge values, both widths, all modes.
    for (int w = 0; w < 2; w++)
      for (int m = 0; m < 4; m++)
        for (int code = 0; code < 64; code++) begin
          for (int i = 0; i < 3; i++)
            put(16'h0010 + 16'(i * (w ? 4 : 2)), pick_val((code >> (2 * i)) & 3, w[0]), w[0]);
          run_case(16'h0010, 16'd1, 3, w[0], m[0], m[1], mode_tag(m[0], m[1], w[0]));
        end

    // R6: zero stride, the same element read repeatedly (ties everywhere).
    put(16'h0040, 64'sd7, 1'b0);
    run_case(16'h0040, 16'd0, 4, 1'b0, 1'b1, 1'b0, "R6 stride 0 max");
    run_case(16'h0040, 16'd0, 4, 1'b0, 1'b0, 1'b0, "R6 stride 0 min");

    // R6: negative stride wrapping below address 0, wide elements.
    for (int i = 0; i < 5; i++)
      put(16'h0004 - 16'(i * 12), longint'({$urandom, $urandom}), 1'b1);
    run_case(16'h0004, 16'hFFFD, 5, 1'b1, 1'b1, 1'b0, "R6 negative wrap max");
    run_case(16'h0004, 16'hFFFD, 5, 1'b1, 1'b0, 1'b1, "R6 negative wrap abs min");

    // R6: wider stride, narrow elements.
    for (int i = 0; i < 8; i++)
      put(16'h0080 + 16'(i * 10), longint'($signed($urandom)), 1'b0);
    run_case(16'h0080, 16'd5, 8, 1'b0, 1'b1, 1'b1, "R6 stride 5 abs max");
    run_case(16'h0080, 16'd5, 8, 1'b0, 1'b0, 1'b0, "R6 stride 5 min");

    // Mixed random runs over lengths, strides and modes.
    for (int r = 0; r < 60; r++) begin
      int n, s;
      bit w, mx, ab;
      longint v;
      n  = 1 + int'($urandom % 8);
      s  = int'($urandom % 7) - 3;
      w  = $urandom % 2;
      mx = $urandom % 2;
      ab = $urandom % 2;
      for (int i = 0; i < n; i++) begin
        if ($urandom % 2) v = pick_val(int'($urandom % 4), w);
        else v = w ? longint'({$urandom, $urandom}) : longint'($signed($urandom % 8));
        put(16'h0100 + 16'(i * s * (w ? 4 : 2)), v, w);
      end
      run_case(16'h0100, 16'(s), n, w, mx, ab, {"R6 ", mode_tag(mx, ab, w)});
    end

    // R8: counts of zero and below.
    short_case(16'd0);
    short_case(16'hFFFB);

    // R11: start pulsed mid-run is ignored.
    begin
      int w0, exp;
      bit seen;
      for (int i = 0; i < 5; i++) put(16'h0020 + 16'(i * 2), longint'(i * 3 - 4), 1'b0);
      exp = ref_idx(16'h0020, 16'd1, 5, 1'b0, 1'b1, 1'b0);
      mem[RES[9:0]] = 16'hDEAD;
      mem[RES2[9:0]] = 16'h1234;
      w0 = wr_cnt;
      seen = 0;
      @(negedge clk);
      start = 1'b1; base_addr = 16'h0020; stride = 16'd1; count = 16'd5;
      wide = 1'b0; find_max = 1'b1; use_abs = 1'b0; result_addr = RES;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      start = 1'b1; count = 16'd1; result_addr = RES2; find_max = 1'b0;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 5000 && !seen; c++) begin
        if (done) seen = 1;
        else @(negedge clk);
      end
      check(seen, "R11 run completes", longint'(seen), 1);
      check(mem[RES[9:0]] == 16'(exp), "R11 result unchanged", longint'(mem[RES[9:0]]), longint'(exp));
      check(mem[RES2[9:0]] == 16'h1234, "R11 no second target", longint'(mem[RES2[9:0]]), 4660);
      check(wr_cnt - w0 == 1, "R11 one write", longint'(wr_cnt - w0), 1);
      repeat (3) @(negedge clk);
      check(!busy && !done, "R11 no restart", longint'({busy, done}), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule